// File: doc/BRIEF.md
# Delay-Slot Macro Sequencer

This block owns the program counter of a small macro engine. A start pulse launches a macro at word 0 of a word-addressed program store. From then on the sequencer fetches one instruction per cycle and hands it to the execute and dispatch units with an execute enable. It also reports whether that instruction sits in a delay slot. At the launch it pulses a clear strobe, so the neighbouring units reset their registers, method address and carry.

Control flow has two delayed forms. A conditional branch tests whether source register A is zero. The zero test comes from the register file as `src_a_zero_i`, computed from the word on `imem_data_i`. A taken branch either runs one delay-slot instruction before it redirects, or, when annulled, redirects at once. An exit flag ends the macro after exactly one further instruction. An exit flag seen inside a delay slot has no effect.

The macro stops early with an error in two cases: the fetch address falls outside the loaded program, or a branch turns up in a delay slot. In both cases the done pulse carries the error flag.

Top module: `mseq_core`

## Requirements
- R1: After reset, busy, done, err, clear and execute enable are low. A start pulse while idle gives `clear_o` high in that same cycle, and instruction word 0 is executed in the next cycle.
- R2: A start pulse while busy is ignored. `clear_o` stays low and the execution sequence is unchanged.
- R3: An instruction is a branch when bits [2:0] equal 7. Branch bit 4 selects the condition: 0 means taken when source A is zero, 1 means taken when source A is non-zero.
- R4: The branch target is the branch's own word address plus the sign-extended immediate in bits [31:14], counted in words.
- R5: A taken branch with bit 5 clear executes the following word as a delay slot (`exec_slot_o` high). The next instruction after that slot is the target.
- R6: A taken branch with bit 5 set executes the target in the very next cycle, and that instruction is not a delay slot.
- R7: A branch that is not taken continues at the next word.
- R8: An instruction with bit 7 set that is not in a delay slot is followed by exactly one more instruction, executed as a delay slot. Done then follows.
- R9: Bit 7 on an instruction executed in a delay slot does not end the macro.
- R10: Done is a one-cycle pulse in the cycle after the last executed instruction. Busy drops in the same cycle.
- R11: A fetch address at or beyond `prog_len_i`, or a computed address below zero, executes nothing. It ends the macro with done and err pulsed together.
- R12: A branch in a delay slot executes nothing. It ends the macro with done and err pulsed together.
- R13: Every non-branch instruction outside a pending redirect continues at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request (pulse) |
| prog_len_i | input | AW+1 | Number of loaded program words |
| src_a_zero_i | input | 1 | Source A of the presented word is zero |
| imem_addr_o | output | AW | Program store word address |
| imem_data_i | input | 32 | Instruction word at `imem_addr_o` |
| clear_o | output | 1 | Clear registers, method address and carry |
| exec_en_o | output | 1 | Execute the presented instruction this cycle |
| exec_slot_o | output | 1 | Presented instruction is a delay slot |
| exec_word_o | output | 32 | Instruction word for the execute units |
| busy_o | output | 1 | Macro running |
| done_o | output | 1 | Macro finished (one cycle) |
| err_o | output | 1 | Macro ended on a fault (with done) |

## Verification
A lost or stale redirect flag shows up on `imem_addr_o` and `exec_slot_o` in the first cycle after the delay slot. The wrong word is executed and the slot marking is wrong. A bad exit-pending bit shows within one instruction: done either comes early, or fails to come and the run continues into other words. The bench sweeps every condition, annul, zero, exit and offset combination around one branch, and compares every cycle against an arithmetic model. Address faults and slot faults each surface within one cycle as an err pulse without an execute enable.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int WORD_W    = 32;
  localparam int IMM_W     = 18;
  localparam int OP_W      = 3;
  localparam logic [OP_W-1:0] OP_BRANCH = 3'd7;
  localparam int COND_BIT  = 4;
  localparam int ANNUL_BIT = 5;
  localparam int EXIT_BIT  = 7;
  localparam int IMM_LSB   = 14;

  typedef struct packed {
    logic             is_br;
    logic             cond_nz;
    logic             annul;
    logic             exit_f;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic             cond_i,
  input  logic             annul_i,
  input  logic             exit_i,
  input  logic [IMM_W-1:0] imm_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o.is_br   = (op_i == OP_BRANCH);
    dec_o.cond_nz = cond_i;
    dec_o.annul   = annul_i;
    dec_o.exit_f  = exit_i;
    dec_o.imm     = imm_i;
  end
endmodule

// File: rtl/mseq_pcgen.sv
module mseq_pcgen #(
  parameter int AW   = 6,
  parameter int OFFW = 18
) (
  input  logic [AW-1:0]   pc_i,
  input  logic [OFFW-1:0] off_i,
  output logic [AW-1:0]   nxt_o,
  output logic            bad_o
);
  localparam int SW = ((AW > OFFW) ? AW : OFFW) + 2;

  logic [SW-1:0] sum;

  always_comb begin
    sum   = {{(SW-AW){1'b0}}, pc_i} + {{(SW-OFFW){off_i[OFFW-1]}}, off_i};
    nxt_o = sum[AW-1:0];
    bad_o = |sum[SW-1:AW];
  end
endmodule

// File: rtl/mseq_core.sv
module mseq_core
  import mseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW:0]       prog_len_i,
  input  logic              src_a_zero_i,
  output logic [AW-1:0]     imem_addr_o,
  input  logic [WORD_W-1:0] imem_data_i,
  output logic              clear_o,
  output logic              exec_en_o,
  output logic              exec_slot_o,
  output logic [WORD_W-1:0] exec_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  dec_t dec;

  logic          busy_q, busy_n;
  logic [AW-1:0] pc_q, pc_n;
  logic          pcbad_q, pcbad_n;
  logic          slot_q, slot_n;
  logic          redir_q, redir_n;
  logic          exitp_q, exitp_n;
  logic [AW-1:0] tgt_q, tgt_n;
  logic          tgtbad_q, tgtbad_n;
  logic          done_q, done_n;
  logic          err_q, err_n;

  logic [AW-1:0] inc_pc, br_pc;
  logic          inc_bad, br_bad;
  logic          fetch_bad, fault, taken, finish, exec_en;

  mseq_decode u_dec (
    .op_i    (imem_data_i[OP_W-1:0]),
    .cond_i  (imem_data_i[COND_BIT]),
    .annul_i (imem_data_i[ANNUL_BIT]),
    .exit_i  (imem_data_i[EXIT_BIT]),
    .imm_i   (imem_data_i[IMM_LSB +: IMM_W]),
    .dec_o   (dec)
  );

  mseq_pcgen #(.AW(AW), .OFFW(IMM_W)) u_inc (
    .pc_i (pc_q), .off_i (IMM_W'(1)), .nxt_o (inc_pc), .bad_o (inc_bad)
  );

  mseq_pcgen #(.AW(AW), .OFFW(IMM_W)) u_br (
    .pc_i (pc_q), .off_i (dec.imm), .nxt_o (br_pc), .bad_o (br_bad)
  );

  always_comb begin
    fetch_bad = pcbad_q || ({1'b0, pc_q} >= prog_len_i);
    fault     = busy_q && (fetch_bad || (dec.is_br && slot_q));
    exec_en   = busy_q && !fault;
    taken     = dec.is_br && (dec.cond_nz ? !src_a_zero_i : src_a_zero_i);
    finish    = exec_en && slot_q && exitp_q;
  end

  always_comb begin
    busy_n   = busy_q;
    pc_n     = pc_q;
    pcbad_n  = pcbad_q;
    slot_n   = slot_q;
    redir_n  = redir_q;
    exitp_n  = exitp_q;
    tgt_n    = tgt_q;
    tgtbad_n = tgtbad_q;
    done_n   = 1'b0;
    err_n    = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_n  = 1'b1;
        pc_n    = '0;
        pcbad_n = 1'b0;
        slot_n  = 1'b0;
        redir_n = 1'b0;
        exitp_n = 1'b0;
      end
    end else if (fault) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      err_n  = 1'b1;
    end else if (finish) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end else if (slot_q) begin
      pc_n    = redir_q ? tgt_q : inc_pc;
      pcbad_n = redir_q ? tgtbad_q : inc_bad;
      slot_n  = 1'b0;
      redir_n = 1'b0;
      exitp_n = 1'b0;
    end else begin
      exitp_n = dec.exit_f;
      if (taken && dec.annul) begin
        pc_n    = br_pc;
        pcbad_n = br_bad;
        slot_n  = dec.exit_f;
        redir_n = 1'b0;
      end else if (taken) begin
        pc_n     = inc_pc;
        pcbad_n  = inc_bad;
        slot_n   = 1'b1;
        redir_n  = 1'b1;
        tgt_n    = br_pc;
        tgtbad_n = br_bad;
      end else begin
        pc_n    = inc_pc;
        pcbad_n = inc_bad;
        slot_n  = dec.exit_f;
        redir_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pc_q     <= '0;
      pcbad_q  <= 1'b0;
      slot_q   <= 1'b0;
      redir_q  <= 1'b0;
      exitp_q  <= 1'b0;
      tgt_q    <= '0;
      tgtbad_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      busy_q   <= busy_n;
      pc_q     <= pc_n;
      pcbad_q  <= pcbad_n;
      slot_q   <= slot_n;
      redir_q  <= redir_n;
      exitp_q  <= exitp_n;
      tgt_q    <= tgt_n;
      tgtbad_q <= tgtbad_n;
      done_q   <= done_n;
      err_q    <= err_n;
    end
  end

  assign imem_addr_o = pc_q;
  assign clear_o     = start_i && !busy_q;
  assign exec_en_o   = exec_en;
  assign exec_slot_o = slot_q;
  assign exec_word_o = imem_data_i;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          src_a_zero_i,
  input logic [AW-1:0] imem_addr_o,
  input logic [2:0]    op_f,
  input logic          cond_f,
  input logic          annul_f,
  input logic          exit_f,
  input logic          clear_o,
  input logic          exec_en_o,
  input logic          exec_slot_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  logic is_br, not_taken;
  assign is_br     = (op_f == 3'd7);
  assign not_taken = is_br && (cond_f ? src_a_zero_i : !src_a_zero_i);

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> (busy_o && imem_addr_o == '0 && !exec_slot_o)); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !clear_o); // R2
  AST_SLOT_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_slot_o && busy_o) |-> $past(exec_en_o)); // R5
  AST_ANNUL_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en_o && is_br && annul_f && !exit_f && !not_taken) |=> !exec_slot_o); // R6
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en_o && not_taken) |=> (imem_addr_o == $past(imem_addr_o) + 1'b1)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R11
  AST_NO_SLOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_slot_o && busy_o && is_br) |-> !exec_en_o); // R12
endmodule

bind mseq_core mseq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .src_a_zero_i (src_a_zero_i),
  .imem_addr_o  (imem_addr_o),
  .op_f         (imem_data_i[2:0]),
  .cond_f       (imem_data_i[4]),
  .annul_f      (imem_data_i[5]),
  .exit_f       (imem_data_i[7]),
  .clear_o      (clear_o),
  .exec_en_o    (exec_en_o),
  .exec_slot_o  (exec_slot_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/test_mseq_core.sv
module test_mseq_core;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW:0] prog_len_i = '0;
  logic src_a_zero_i;
  logic [AW-1:0] imem_addr_o;
  logic [31:0] imem_data_i;
  logic clear_o, exec_en_o, exec_slot_o, busy_o, done_o, err_o;
  logic [31:0] exec_word_o;

  logic [31:0] mem [DEPTH];
  logic [7:0]  zvec = 8'h01;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign imem_data_i  = mem[imem_addr_o];
  assign src_a_zero_i = zvec[imem_data_i[13:11]];

  mseq_core #(.AW(AW)) i_mseq_core (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_len_i(prog_len_i),
    .src_a_zero_i(src_a_zero_i), .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
    .clear_o(clear_o), .exec_en_o(exec_en_o), .exec_slot_o(exec_slot_o),
    .exec_word_o(exec_word_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] filler(input int i);
    return 32'h5A5A_0300 | 32'(i % 7);
  endfunction

  function automatic logic [31:0] branch(input bit nz, input bit an, input bit ex, input int off);
    logic [17:0] imm = 18'(off);
    return 32'h7 | (32'(nz) << 4) | (32'(an) << 5) | (32'(ex) << 7) | (32'd1 << 11) | ({14'd0, imm} << 14);
  endfunction

  // Runs one macro and compares every cycle with an arithmetic model.
  task automatic run_prog(input int len, input int poke);
    int mpc = 0;
    bit mslot = 0, mredir = 0, mexit = 0;
    int mtgt = 0;
    string tag = "R1";
    prog_len_i = (AW+1)'(len);
    @(negedge clk);
    start_i = 1'b1;
    #1 chk(clear_o == 1'b1, "R1 clear on start", 32'(clear_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      logic [31:0] w;
      bit br, tk;
      if (cyc == poke) begin
        start_i = 1'b1;
        #1 chk(clear_o == 1'b0, "R2 start while busy", 32'(clear_o), 0);
      end
      #1;
      w  = (mpc >= 0 && mpc < len) ? mem[mpc] : 32'h0;
      br = (w[2:0] == 3'd7);
      if (mpc < 0 || mpc >= len || (br && mslot)) begin
        tag = (mpc < 0 || mpc >= len) ? "R11" : "R12";
        chk(exec_en_o == 1'b0, {tag, " no exec on fault"}, 32'(exec_en_o), 0);
        @(negedge clk); start_i = 1'b0;
        chk(done_o && err_o && !busy_o, {tag, " done+err"}, {done_o, err_o, busy_o}, 3'b110);
        @(negedge clk);
        chk(!done_o && !err_o, "R10 done single cycle", {done_o, err_o}, 0);
        return;
      end
      chk(exec_en_o == 1'b1, {tag, " exec enable"}, 32'(exec_en_o), 1);
      chk(imem_addr_o == AW'(mpc), {tag, " address"}, 32'(imem_addr_o), 32'(mpc));
      chk(exec_slot_o == mslot, mslot ? "R5 slot flag" : "R6 slot flag", 32'(exec_slot_o), 32'(mslot));
      if (mslot && mexit) begin
        @(negedge clk); start_i = 1'b0;
        chk(done_o && !err_o && !busy_o, "R8 done after exit slot", {done_o, err_o, busy_o}, 3'b100);
        @(negedge clk);
        chk(!done_o && !busy_o, "R10 done single cycle", {done_o, busy_o}, 0);
        return;
      end
      if (mslot) begin
        tag = mredir ? "R4" : (w[7] ? "R9" : "R13");
        mpc = mredir ? mtgt : mpc + 1;
        mslot = 0; mredir = 0; mexit = 0;
      end else begin
        tk = br && (w[4] ? !zvec[w[13:11]] : zvec[w[13:11]]);
        mexit = w[7];
        if (tk && w[5]) begin
          tag = "R3"; mpc = mpc + int'($signed(w[31:14])); mslot = w[7]; mredir = 0;
        end else if (tk) begin
          tag = "R5"; mtgt = mpc + int'($signed(w[31:14])); mpc = mpc + 1; mslot = 1; mredir = 1;
        end else begin
          tag = br ? "R7" : (w[7] ? "R8" : "R13"); mpc = mpc + 1; mslot = w[7]; mredir = 0;
        end
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    chk(1'b0, "R10 run did not end", 0, 1);
  endtask

  initial begin
    int offs [5] = '{1, 3, 6, 8, -3};
    for (int i = 0; i < DEPTH; i++) mem[i] = filler(i);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !exec_en_o && !clear_o, "R1 reset state",
        {busy_o, done_o, err_o, exec_en_o, clear_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep around one branch at word 2; exit at word 9.
    for (int nz = 0; nz < 2; nz++)
      for (int an = 0; an < 2; an++)
        for (int zr = 0; zr < 2; zr++)
          for (int bx = 0; bx < 2; bx++)
            for (int sx = 0; sx < 2; sx++)
              for (int o = 0; o < 5; o++) begin
                for (int i = 0; i < DEPTH; i++) mem[i] = filler(i);
                mem[9] = filler(9) | 32'h80;
                mem[3] = filler(3) | (32'(sx) << 7);
                mem[2] = branch(nz[0], an[0], bx[0], offs[o]);
                zvec = {6'd0, zr[0], 1'b1};
                run_prog(12, 2);
              end

    // Branch inside a branch delay slot.
    for (int i = 0; i < DEPTH; i++) mem[i] = filler(i);
    mem[2] = branch(1'b0, 1'b0, 1'b0, 4);
    mem[3] = branch(1'b0, 1'b0, 1'b0, 1);
    zvec = 8'h01;
    mem[2][13:11] = 3'd0;
    run_prog(12, 1);

    // Branch inside an exit slot.
    for (int i = 0; i < DEPTH; i++) mem[i] = filler(i);
    mem[4] = filler(4) | 32'h80;
    mem[5] = branch(1'b1, 1'b1, 1'b0, 2);
    run_prog(12, 1);

    // Running off the end, including the full store and an empty program.
    for (int i = 0; i < DEPTH; i++) mem[i] = filler(i);
    run_prog(5, 3);
    run_prog(DEPTH, 10);
    run_prog(0, 100);

    // Exit on the very first word.
    mem[0] = filler(0) | 32'h80;
    run_prog(8, 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule